// File: doc/BRIEF.md
# Line activation state controller

This block sequences a line-termination repeater through the bring-up and shutdown of a digital subscriber line. It takes decoded commands from the local control side, a handful of receiver detector flags and the expiry of its own timers. From these it decides which signal element to send toward the line and which status code to report back. Activation runs through a fixed handshake: wake-up tone, echo-canceller training, equalizer training, a timed pending phase and then transparent data. Reset and test commands override every state. Loss of frame and loss of signal each have their own recovery path, and both end in a timed teardown.

The state register, the transition logic, the registered output decode and a bank of five down-counter timers are all inside the block. The transmitted element, the status code and the timer start strobes change on the same clock edge as the state. The status code changes only when the state changes, or when the far-end fault flag changes while the line is transparent.

Top module: `lt_act_ctrl`

## Requirements
- R1: Synchronous `rst`, `pfail_i`, or command code 1 (reset) moves the block to idle on the next edge from any state. Idle sends element 0 (quiet) and reports status 0.
- R2: Command code 2 (test) moves the block to test from any state, unless a reset request is also present. Test sends element 0 and reports status 10. Test is left only through a reset request.
- R3: In idle, command code 3 (activate) enters the awake state. Awake sends element 1 (wake), reports status 1 and pulses timer start bit 1 (awake window).
- R4: In awake, `lsig_i` enters echo training (element 2, status 1, start bit 2). If the awake window expires first, the block enters awake-error (element 1, status 14). Awake-error leaves on `lsig_i` to echo training, or on command code 4 back to idle.
- R5: Echo training moves to echo-done (element 2, status 2) on `ecconv_i` or on expiry of the training timer. Echo-done moves to equalizer training (element 2, status 2) on `remack_i`.
- R6: Equalizer training moves to pending only when `fsync_i` is high together with at least one of `blk1_i`, `blk0_i` or `crcok_i`. Pending sends element 3 (data), reports status 3 and pulses start bit 3. `fsync_i` alone has no effect.
- R7: Pending moves to transparent on the edge after its timer expires, which is LD_PX+1 cycles after entry. Transparent sends element 3 and reports status 4, or status 5 while `fj_i` is high.
- R8: `lof_i` in pending or transparent enters loss-of-sync (element 3, status 6, start bit 4). From loss-of-sync, `fsync_i` returns to transparent. If the teardown timer expires first, the block enters teardown-error (element 0, status 9).
- R9: `los_i` in pending, transparent or loss-of-sync enters loss-of-signal (element 3, status 7, start bit 4), and takes priority over `lof_i`. On timer expiry it moves to receiver reset (element 0, status 7).
- R10: Command code 4 (deactivate) in transparent enters pending-deactivation (element 3, status 8, start bit 4). On timer expiry it moves to teardown (element 0, status 8).
- R11: Teardown, teardown-error and receiver reset each return to idle on expiry of the teardown timer. Each of them restarts that timer on entry.
- R12: Each timer expires exactly LD cycles after its start and never for two cycles in a row. At most one start bit is high per cycle. Element, status and start bits are registered and change on the same edge as the state.
- R13: In idle, command code 5 (alert) enters ringing (element 0, status 11, start bit 0). Ringing returns to idle on guard expiry, or goes to awake on command 3. Command code 6 enters loop reset (status 12, start bit 0). On guard expiry, loop reset moves to wait (status 13). Wait moves to awake on command 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code, 0 = none |
| pfail_i | input | 1 | Power-fail request, acts as reset |
| lsig_i | input | 1 | Far end answered the wake tone |
| ecconv_i | input | 1 | Echo canceller converged |
| remack_i | input | 1 | Far end acknowledges training |
| fsync_i | input | 1 | Frame sync found |
| blk1_i | input | 1 | Block check 1 good |
| blk0_i | input | 1 | Block check 0 good |
| crcok_i | input | 1 | CRC good |
| lof_i | input | 1 | Loss of frame |
| los_i | input | 1 | Loss of signal |
| fj_i | input | 1 | Far-end fault flag |
| tx_o | output | 2 | Line element to send (0 quiet, 1 wake, 2 train, 3 data) |
| ind_o | output | 4 | Status code to local side |
| tmr_start_o | output | 5 | Timer start strobes (0 guard, 1 awake, 2 echo, 3 pending, 4 teardown) |

## Verification
The bench checks that a reset given while the block sits in loss-of-sync lands in idle at once. A design that let the state-specific logic win would keep sending data. It checks that frame sync without any good block or CRC leaves equalizer training untouched, so a gate that is too loose would reach pending early. It drives loss of frame and loss of signal in the same cycle and expects loss-of-signal, which catches a swapped priority. It counts the dwell in each timed state, so an off-by-one in the timer reload or a missing restart on entry shows up as an early or late change of status.

// File: rtl/lt_act_pkg.sv
package lt_act_pkg;

    localparam int NTMR     = 5;
    localparam int TM_GUARD = 0;
    localparam int TM_AWK   = 1;
    localparam int TM_EC    = 2;
    localparam int TM_PX    = 3;
    localparam int TM_TD    = 4;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_RESET = 3'd1,
        CMD_TEST  = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_DEACT = 3'd4,
        CMD_ALERT = 3'd5,
        CMD_LOOP  = 3'd6,
        CMD_RSVD  = 3'd7
    } cmd_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_RING, ST_LOOP_RST, ST_WAIT_NET, ST_AWAKE, ST_AWAKE_ERR,
        ST_EC_TRAIN, ST_EC_DONE, ST_EQ_TRAIN, ST_PEND_XP, ST_XPARENT,
        ST_LOSYNC, ST_LOS, ST_PEND_DEACT, ST_RX_RST, ST_TEARDOWN,
        ST_TD_ERR, ST_TEST
    } state_e;

    typedef enum logic [1:0] {
        TX_QUIET = 2'd0,
        TX_WAKE  = 2'd1,
        TX_TRAIN = 2'd2,
        TX_DATA  = 2'd3
    } tx_e;

    typedef enum logic [3:0] {
        IND_IDLE     = 4'd0,
        IND_WAKE     = 4'd1,
        IND_TRAINED  = 4'd2,
        IND_PENDING  = 4'd3,
        IND_UP       = 4'd4,
        IND_UP_FAULT = 4'd5,
        IND_RESYNC   = 4'd6,
        IND_NOSIG    = 4'd7,
        IND_DOWN     = 4'd8,
        IND_DOWN_ERR = 4'd9,
        IND_TEST     = 4'd10,
        IND_RING     = 4'd11,
        IND_LOOP     = 4'd12,
        IND_WAIT     = 4'd13,
        IND_WAKE_ERR = 4'd14,
        IND_RSVD     = 4'd15
    } ind_e;

    typedef struct packed {
        tx_e  tx;
        ind_e ind;
    } lineout_t;

    function automatic tx_e tx_of(state_e s);
        case (s)
            ST_AWAKE, ST_AWAKE_ERR:                 return TX_WAKE;
            ST_EC_TRAIN, ST_EC_DONE, ST_EQ_TRAIN:   return TX_TRAIN;
            ST_PEND_XP, ST_XPARENT, ST_LOSYNC,
            ST_LOS, ST_PEND_DEACT:                  return TX_DATA;
            default:                                return TX_QUIET;
        endcase
    endfunction

    function automatic ind_e ind_of(state_e s, logic fault);
        case (s)
            ST_RING:       return IND_RING;
            ST_LOOP_RST:   return IND_LOOP;
            ST_WAIT_NET:   return IND_WAIT;
            ST_AWAKE,
            ST_EC_TRAIN:   return IND_WAKE;
            ST_AWAKE_ERR:  return IND_WAKE_ERR;
            ST_EC_DONE,
            ST_EQ_TRAIN:   return IND_TRAINED;
            ST_PEND_XP:    return IND_PENDING;
            ST_XPARENT:    return fault ? IND_UP_FAULT : IND_UP;
            ST_LOSYNC:     return IND_RESYNC;
            ST_LOS,
            ST_RX_RST:     return IND_NOSIG;
            ST_PEND_DEACT,
            ST_TEARDOWN:   return IND_DOWN;
            ST_TD_ERR:     return IND_DOWN_ERR;
            ST_TEST:       return IND_TEST;
            default:       return IND_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/lt_act_timer.sv
module lt_act_timer #(
    parameter int unsigned LOAD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expire
);
    localparam int W = $clog2(LOAD + 1);

    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run    <= 1'b0;
            expire <= 1'b0;
        end else if (start) begin
            cnt    <= W'(LOAD);
            run    <= 1'b1;
            expire <= 1'b0;
        end else if (run) begin
            if (cnt == W'(1)) begin
                cnt    <= '0;
                run    <= 1'b0;
                expire <= 1'b1;
            end else begin
                cnt    <= cnt - W'(1);
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end

    // R12: an expiry is a single-cycle strobe
    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R12: a fresh start never expires on the following cycle edge
    assert_start_clears_R12: assert property (@(posedge clk) disable iff (rst)
        start |=> !expire);

endmodule

// File: rtl/lt_act_fsm.sv
module lt_act_fsm import lt_act_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  logic            pfail_i,
    input  logic            lsig_i,
    input  logic            ecconv_i,
    input  logic            remack_i,
    input  logic            fsync_i,
    input  logic            blk1_i,
    input  logic            blk0_i,
    input  logic            crcok_i,
    input  logic            lof_i,
    input  logic            los_i,
    input  logic [NTMR-1:0] tmr_exp,
    output state_e          st_q,
    output state_e          st_n,
    output logic [NTMR-1:0] start_n
);
    logic frame_ok;
    assign frame_ok = fsync_i && (blk1_i || blk0_i || crcok_i);

    always_comb begin
        st_n    = st_q;
        start_n = '0;
        if (pfail_i || cmd == CMD_RESET) begin
            st_n = ST_IDLE;
        end else if (cmd == CMD_TEST) begin
            st_n = ST_TEST;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd == CMD_ACT) begin
                        st_n = ST_AWAKE;    start_n[TM_AWK] = 1'b1;
                    end else if (cmd == CMD_ALERT) begin
                        st_n = ST_RING;     start_n[TM_GUARD] = 1'b1;
                    end else if (cmd == CMD_LOOP) begin
                        st_n = ST_LOOP_RST; start_n[TM_GUARD] = 1'b1;
                    end
                end
                ST_RING: begin
                    if (cmd == CMD_ACT) begin
                        st_n = ST_AWAKE; start_n[TM_AWK] = 1'b1;
                    end else if (tmr_exp[TM_GUARD]) begin
                        st_n = ST_IDLE;
                    end
                end
                ST_LOOP_RST:
                    if (tmr_exp[TM_GUARD]) st_n = ST_WAIT_NET;
                ST_WAIT_NET:
                    if (cmd == CMD_ACT) begin
                        st_n = ST_AWAKE; start_n[TM_AWK] = 1'b1;
                    end
                ST_AWAKE: begin
                    if (lsig_i) begin
                        st_n = ST_EC_TRAIN; start_n[TM_EC] = 1'b1;
                    end else if (tmr_exp[TM_AWK]) begin
                        st_n = ST_AWAKE_ERR;
                    end
                end
                ST_AWAKE_ERR: begin
                    if (lsig_i) begin
                        st_n = ST_EC_TRAIN; start_n[TM_EC] = 1'b1;
                    end else if (cmd == CMD_DEACT) begin
                        st_n = ST_IDLE;
                    end
                end
                ST_EC_TRAIN:
                    if (ecconv_i || tmr_exp[TM_EC]) st_n = ST_EC_DONE;
                ST_EC_DONE:
                    if (remack_i) st_n = ST_EQ_TRAIN;
                ST_EQ_TRAIN:
                    if (frame_ok) begin
                        st_n = ST_PEND_XP; start_n[TM_PX] = 1'b1;
                    end
                ST_PEND_XP: begin
                    if (los_i) begin
                        st_n = ST_LOS;    start_n[TM_TD] = 1'b1;
                    end else if (lof_i) begin
                        st_n = ST_LOSYNC; start_n[TM_TD] = 1'b1;
                    end else if (tmr_exp[TM_PX]) begin
                        st_n = ST_XPARENT;
                    end
                end
                ST_XPARENT: begin
                    if (los_i) begin
                        st_n = ST_LOS;        start_n[TM_TD] = 1'b1;
                    end else if (lof_i) begin
                        st_n = ST_LOSYNC;     start_n[TM_TD] = 1'b1;
                    end else if (cmd == CMD_DEACT) begin
                        st_n = ST_PEND_DEACT; start_n[TM_TD] = 1'b1;
                    end
                end
                ST_LOSYNC: begin
                    if (los_i) begin
                        st_n = ST_LOS;    start_n[TM_TD] = 1'b1;
                    end else if (fsync_i) begin
                        st_n = ST_XPARENT;
                    end else if (tmr_exp[TM_TD]) begin
                        st_n = ST_TD_ERR; start_n[TM_TD] = 1'b1;
                    end
                end
                ST_LOS:
                    if (tmr_exp[TM_TD]) begin
                        st_n = ST_RX_RST; start_n[TM_TD] = 1'b1;
                    end
                ST_PEND_DEACT:
                    if (tmr_exp[TM_TD]) begin
                        st_n = ST_TEARDOWN; start_n[TM_TD] = 1'b1;
                    end
                ST_TEARDOWN, ST_TD_ERR, ST_RX_RST:
                    if (tmr_exp[TM_TD]) st_n = ST_IDLE;
                default: st_n = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    // R1: any reset request lands in idle on the next edge
    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (pfail_i || cmd == CMD_RESET) |=> (st_q == ST_IDLE));

    // R2: a test command without a reset request lands in test
    assert_test_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_TEST && !pfail_i) |=> (st_q == ST_TEST));

    // R2: test is left only through a reset request
    assert_test_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TEST && !pfail_i && cmd != CMD_RESET) |=> (st_q == ST_TEST));

    // R6: pending is reached from equalizer training only with sync plus a good check
    assert_pend_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PEND_XP && $past(st_q) == ST_EQ_TRAIN)
        |-> $past(fsync_i && (blk1_i || blk0_i || crcok_i)));

    // R9: loss of signal outranks loss of frame in transparent
    assert_los_prio_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_XPARENT && los_i && lof_i && cmd == CMD_NONE && !pfail_i)
        |=> (st_q == ST_LOS));

    // R11: teardown holds until its timer expires
    assert_td_dwell_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TEARDOWN && !tmr_exp[TM_TD] && cmd == CMD_NONE && !pfail_i)
        |=> (st_q == ST_TEARDOWN));

endmodule

// File: rtl/lt_act_outreg.sv
module lt_act_outreg import lt_act_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  state_e          st_n,
    input  logic            fj_i,
    input  logic [NTMR-1:0] start_n,
    output lineout_t        out_q,
    output logic [NTMR-1:0] start_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '{tx: TX_QUIET, ind: IND_IDLE};
            start_q <= '0;
        end else begin
            out_q   <= '{tx: tx_of(st_n), ind: ind_of(st_n, fj_i)};
            start_q <= start_n;
        end
    end

    // R12: at most one timer is started per cycle
    assert_start_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_q));

endmodule

// File: rtl/lt_act_ctrl.sv
module lt_act_ctrl import lt_act_pkg::*; #(
    parameter int unsigned LD_GUARD = 6,
    parameter int unsigned LD_AWK   = 20,
    parameter int unsigned LD_EC    = 12,
    parameter int unsigned LD_PX    = 5,
    parameter int unsigned LD_TD    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cmd_i,
    input  logic            pfail_i,
    input  logic            lsig_i,
    input  logic            ecconv_i,
    input  logic            remack_i,
    input  logic            fsync_i,
    input  logic            blk1_i,
    input  logic            blk0_i,
    input  logic            crcok_i,
    input  logic            lof_i,
    input  logic            los_i,
    input  logic            fj_i,
    output logic [1:0]      tx_o,
    output logic [3:0]      ind_o,
    output logic [NTMR-1:0] tmr_start_o
);
    localparam int unsigned LOADS [NTMR] = '{LD_GUARD, LD_AWK, LD_EC, LD_PX, LD_TD};

    cmd_e            cmd;
    state_e          st_q;
    state_e          st_n;
    logic [NTMR-1:0] start_n;
    logic [NTMR-1:0] tmr_exp;
    lineout_t        out_q;

    assign cmd = cmd_e'(cmd_i);

    lt_act_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pfail_i  (pfail_i),
        .lsig_i   (lsig_i),
        .ecconv_i (ecconv_i),
        .remack_i (remack_i),
        .fsync_i  (fsync_i),
        .blk1_i   (blk1_i),
        .blk0_i   (blk0_i),
        .crcok_i  (crcok_i),
        .lof_i    (lof_i),
        .los_i    (los_i),
        .tmr_exp  (tmr_exp),
        .st_q     (st_q),
        .st_n     (st_n),
        .start_n  (start_n)
    );

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        lt_act_timer #(.LOAD(LOADS[g])) i_tmr (
            .clk    (clk),
            .rst    (rst),
            .start  (start_n[g]),
            .expire (tmr_exp[g])
        );
    end

    lt_act_outreg i_out (
        .clk     (clk),
        .rst     (rst),
        .st_n    (st_n),
        .fj_i    (fj_i),
        .start_n (start_n),
        .out_q   (out_q),
        .start_q (tmr_start_o)
    );

    assign tx_o  = out_q.tx;
    assign ind_o = out_q.ind;

    // R1: idle always shows quiet line and idle status
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (tx_o == TX_QUIET && ind_o == IND_IDLE));

    // R7: transparent always sends data
    assert_xp_data_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_XPARENT) |-> (tx_o == TX_DATA));

    // R3: entering awake pulses the awake-window start bit
    assert_awake_start_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AWAKE && $past(st_q) != ST_AWAKE) |-> tmr_start_o[TM_AWK]);

endmodule

// File: tb/test_lt_act_ctrl.sv
`timescale 1ns/1ps
module test_lt_act_ctrl;

    localparam int B_GUARD = 6;
    localparam int B_AWK   = 20;
    localparam int B_EC    = 12;
    localparam int B_PX    = 5;
    localparam int B_TD    = 8;

    // model state numbers (bench-local)
    localparam int M_IDLE = 0, M_RING = 1, M_LOOP = 2, M_WAIT = 3, M_AWAKE = 4,
                   M_AWERR = 5, M_ECT = 6, M_ECD = 7, M_EQT = 8, M_PEND = 9,
                   M_XP = 10, M_LOSY = 11, M_LOS = 12, M_PDEA = 13, M_RXR = 14,
                   M_TDN = 15, M_TDE = 16, M_TEST = 17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd_i = 3'd0;
    logic       pfail_i = 0, lsig_i = 0, ecconv_i = 0, remack_i = 0;
    logic       fsync_i = 0, blk1_i = 0, blk0_i = 0, crcok_i = 0;
    logic       lof_i = 0, los_i = 0, fj_i = 0;
    logic [1:0] tx_o;
    logic [3:0] ind_o;
    logic [4:0] tmr_start_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    lt_act_ctrl #(
        .LD_GUARD(B_GUARD), .LD_AWK(B_AWK), .LD_EC(B_EC), .LD_PX(B_PX), .LD_TD(B_TD)
    ) i_lt_act_ctrl (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .pfail_i(pfail_i), .lsig_i(lsig_i),
        .ecconv_i(ecconv_i), .remack_i(remack_i), .fsync_i(fsync_i),
        .blk1_i(blk1_i), .blk0_i(blk0_i), .crcok_i(crcok_i), .lof_i(lof_i),
        .los_i(los_i), .fj_i(fj_i), .tx_o(tx_o), .ind_o(ind_o),
        .tmr_start_o(tmr_start_o)
    );

    // ---------------- reference model ----------------
    int m_st = M_IDLE;
    int m_tx = 0;
    int m_ind = 0;
    int m_start = 0;
    int m_cnt [5];
    bit m_run [5];
    bit m_exp [5];
    int nx;
    int sidx;

    function automatic int exp_tx(int s);
        if (s == M_AWAKE || s == M_AWERR) return 1;
        if (s == M_ECT || s == M_ECD || s == M_EQT) return 2;
        if (s == M_PEND || s == M_XP || s == M_LOSY || s == M_LOS || s == M_PDEA) return 3;
        return 0;
    endfunction

    function automatic int exp_ind(int s, bit f);
        case (s)
            M_RING: return 11;  M_LOOP: return 12;  M_WAIT: return 13;
            M_AWAKE, M_ECT: return 1;  M_AWERR: return 14;
            M_ECD, M_EQT: return 2;  M_PEND: return 3;
            M_XP: return f ? 5 : 4;  M_LOSY: return 6;
            M_LOS, M_RXR: return 7;  M_PDEA, M_TDN: return 8;
            M_TDE: return 9;  M_TEST: return 10;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = M_IDLE; m_tx = 0; m_ind = 0; m_start = 0;
            for (int k = 0; k < 5; k++) begin
                m_cnt[k] = 0; m_run[k] = 0; m_exp[k] = 0;
            end
        end else begin
            nx = m_st; sidx = -1;
            if (pfail_i || cmd_i == 3'd1) nx = M_IDLE;
            else if (cmd_i == 3'd2) nx = M_TEST;
            else begin
                case (m_st)
                    M_IDLE:  if (cmd_i == 3'd3) begin nx = M_AWAKE; sidx = 1; end
                             else if (cmd_i == 3'd5) begin nx = M_RING; sidx = 0; end
                             else if (cmd_i == 3'd6) begin nx = M_LOOP; sidx = 0; end
                    M_RING:  if (cmd_i == 3'd3) begin nx = M_AWAKE; sidx = 1; end
                             else if (m_exp[0]) nx = M_IDLE;
                    M_LOOP:  if (m_exp[0]) nx = M_WAIT;
                    M_WAIT:  if (cmd_i == 3'd3) begin nx = M_AWAKE; sidx = 1; end
                    M_AWAKE: if (lsig_i) begin nx = M_ECT; sidx = 2; end
                             else if (m_exp[1]) nx = M_AWERR;
                    M_AWERR: if (lsig_i) begin nx = M_ECT; sidx = 2; end
                             else if (cmd_i == 3'd4) nx = M_IDLE;
                    M_ECT:   if (ecconv_i || m_exp[2]) nx = M_ECD;
                    M_ECD:   if (remack_i) nx = M_EQT;
                    M_EQT:   if (fsync_i && (blk1_i || blk0_i || crcok_i)) begin nx = M_PEND; sidx = 3; end
                    M_PEND:  if (los_i) begin nx = M_LOS; sidx = 4; end
                             else if (lof_i) begin nx = M_LOSY; sidx = 4; end
                             else if (m_exp[3]) nx = M_XP;
                    M_XP:    if (los_i) begin nx = M_LOS; sidx = 4; end
                             else if (lof_i) begin nx = M_LOSY; sidx = 4; end
                             else if (cmd_i == 3'd4) begin nx = M_PDEA; sidx = 4; end
                    M_LOSY:  if (los_i) begin nx = M_LOS; sidx = 4; end
                             else if (fsync_i) nx = M_XP;
                             else if (m_exp[4]) begin nx = M_TDE; sidx = 4; end
                    M_LOS:   if (m_exp[4]) begin nx = M_RXR; sidx = 4; end
                    M_PDEA:  if (m_exp[4]) begin nx = M_TDN; sidx = 4; end
                    M_TDN, M_TDE, M_RXR: if (m_exp[4]) nx = M_IDLE;
                    default: nx = m_st;
                endcase
            end
            for (int k = 0; k < 5; k++) begin
                if (sidx == k) begin
                    m_cnt[k] = (k == 0) ? B_GUARD : (k == 1) ? B_AWK :
                               (k == 2) ? B_EC : (k == 3) ? B_PX : B_TD;
                    m_run[k] = 1; m_exp[k] = 0;
                end else if (m_run[k]) begin
                    if (m_cnt[k] == 1) begin m_cnt[k] = 0; m_run[k] = 0; m_exp[k] = 1; end
                    else begin m_cnt[k] = m_cnt[k] - 1; m_exp[k] = 0; end
                end else m_exp[k] = 0;
            end
            m_st    = nx;
            m_tx    = exp_tx(nx);
            m_ind   = exp_ind(nx, fj_i);
            m_start = (sidx >= 0) ? (1 << sidx) : 0;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic compare_model();
        total++;
        if (int'(tx_o) != m_tx || int'(ind_o) != m_ind || int'(tmr_start_o) != m_start) begin
            bad++;
            $display("FAIL R12 cycle model: tx=%0d ind=%0d start=%b expected tx=%0d ind=%0d start=%b",
                     tx_o, ind_o, tmr_start_o, m_tx, m_ind, m_start[4:0]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare_model();
    endtask

    task automatic chk(string tag, int etx, int eind);
        total++;
        if (int'(tx_o) != etx || int'(ind_o) != eind) begin
            bad++;
            $display("FAIL %s: tx=%0d ind=%0d expected tx=%0d ind=%0d", tag, tx_o, ind_o, etx, eind);
        end
    endtask

    task automatic chk_start(string tag, int estart);
        total++;
        if (int'(tmr_start_o) != estart) begin
            bad++;
            $display("FAIL %s: start=%b expected %b", tag, tmr_start_o, estart[4:0]);
        end
    endtask

    task automatic pulse_cmd(logic [2:0] c);
        cmd_i = c;
        tick();
        cmd_i = 3'd0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic activate();
        pulse_cmd(3'd3);
        lsig_i = 1; tick(); lsig_i = 0;
        ecconv_i = 1; tick(); ecconv_i = 0;
        remack_i = 1; tick(); remack_i = 0;
        fsync_i = 1; crcok_i = 1; tick(); fsync_i = 0; crcok_i = 0;
        run(B_PX + 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenario ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        chk("R1 reset state", 0, 0);
        chk_start("R1 reset start bits", 0);

        // full activation
        pulse_cmd(3'd3);
        chk("R3 awake", 1, 1);
        chk_start("R3 awake timer start", 5'b00010);

        // let the awake window lapse
        run(B_AWK);
        chk("R4 awake still before expiry", 1, 1);
        tick();
        chk("R4 awake error", 1, 14);

        lsig_i = 1; tick(); lsig_i = 0;
        chk("R4 echo training", 2, 1);
        chk_start("R4 echo timer start", 5'b00100);

        ecconv_i = 1; tick(); ecconv_i = 0;
        chk("R5 echo done", 2, 2);
        remack_i = 1; tick(); remack_i = 0;
        chk("R5 equalizer training", 2, 2);

        fsync_i = 1; run(3);
        chk("R6 sync alone ignored", 2, 2);
        blk0_i = 1; tick(); fsync_i = 0; blk0_i = 0;
        chk("R6 pending", 3, 3);
        chk_start("R6 pending timer start", 5'b01000);

        run(B_PX);
        chk("R7 pending before expiry", 3, 3);
        tick();
        chk("R7 transparent", 3, 4);
        fj_i = 1; tick();
        chk("R7 transparent with fault", 3, 5);
        fj_i = 0; tick();
        chk("R7 fault cleared", 3, 4);

        // loss of frame, recovery, loss again, reset mid-state
        lof_i = 1; tick();
        chk("R8 loss of sync", 3, 6);
        chk_start("R8 teardown timer start", 5'b10000);
        lof_i = 0; fsync_i = 1; tick(); fsync_i = 0;
        chk("R8 resync to transparent", 3, 4);
        lof_i = 1; tick(); lof_i = 0;
        chk("R8 loss of sync again", 3, 6);
        pulse_cmd(3'd1);
        chk("R1 reset from loss of sync", 0, 0);

        // loss of signal path with priority over loss of frame
        activate();
        chk("R7 transparent second run", 3, 4);
        lof_i = 1; los_i = 1; tick(); lof_i = 0; los_i = 0;
        chk("R9 loss of signal wins", 3, 7);
        run(B_TD + 1);
        chk("R9 receiver reset", 0, 7);
        run(B_TD);
        chk("R11 receiver reset dwell", 0, 7);
        tick();
        chk("R11 receiver reset to idle", 0, 0);

        // loss of sync timing out into teardown error
        activate();
        lof_i = 1; tick(); lof_i = 0;
        run(B_TD + 1);
        chk("R8 teardown error", 0, 9);
        run(B_TD + 1);
        chk("R11 teardown error to idle", 0, 0);

        // orderly deactivation
        activate();
        pulse_cmd(3'd4);
        chk("R10 pending deactivation", 3, 8);
        run(B_TD + 1);
        chk("R10 teardown", 0, 8);
        run(B_TD + 1);
        chk("R11 teardown to idle", 0, 0);

        // test mode override and exit
        activate();
        pulse_cmd(3'd2);
        chk("R2 test from transparent", 0, 10);
        pulse_cmd(3'd3);
        chk("R2 activate ignored in test", 0, 10);
        los_i = 1; tick(); los_i = 0;
        chk("R2 loss of signal ignored in test", 0, 10);
        pfail_i = 1; tick(); pfail_i = 0;
        chk("R1 power fail to idle", 0, 0);

        // alert and loop paths
        pulse_cmd(3'd5);
        chk("R13 ringing", 0, 11);
        chk_start("R13 guard start", 5'b00001);
        run(B_GUARD + 1);
        chk("R13 ringing to idle", 0, 0);
        pulse_cmd(3'd6);
        chk("R13 loop reset", 0, 12);
        run(B_GUARD + 1);
        chk("R13 wait", 0, 13);
        pulse_cmd(3'd3);
        chk("R13 wait to awake", 1, 1);

        // awake error back to idle by deactivate
        run(B_AWK + 1);
        chk("R4 awake error second", 1, 14);
        pulse_cmd(3'd4);
        chk("R4 awake error to idle", 0, 0);

        run(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule